// File: doc/BRIEF.md
# Flash Completion Interrupt Capture

This block gathers completion interrupts from a configurable number of external flash devices and hands them to the host through two latched levels. Each device interrupt input is resynchronised and watched for a low-to-high transition. Such a transition sets a per-device done flag. When that flag rises and the device is not masked, it sets a per-device controller status bit. Any set status bit drives the single processor interrupt line.

Software has two ways to see a completion. It can poll the done flags through the register port, or it can wait for the interrupt. Each level is cleared separately by writing ones to its own clear register. The intended service order is to clear the done flag first and then the controller status bit. A status bit fires once for each rising of its unmasked done flag. It does not fire again while the done flag simply stays set.

The register port is a single-cycle write strobe with a 3-bit address. The read data is a combinational function of the address. Every register is one bit per device, with bit x belonging to device x.

Top module: `flash_irq_capture`

## Requirements
- R1: Register map, by address: 0 = done flags (read only); 1 = done clear (write-one-to-clear, reads 0); 2 = mask (read/write); 3 = controller status (read only); 4 = status clear (write-one-to-clear, reads 0). After reset the done flags and the status bits are 0, the mask is all ones and `irq` is 0.
- R2: Assume `dev_int[x]` is driven high before clock edge k. Done flag x then reads 1 after clock edge k+2 and reads 0 before that edge.
- R3: An input that stays high after its flag has been cleared does not set the done flag again. A falling input does not set it either.
- R4: With mask bit x at 0, status bit x becomes 1 one clock after done flag x rises. `irq` is high in that same cycle.
- R5: With mask bit x at 1, status bit x stays 0. Clearing mask bit x while done flag x is still 1 sets status bit x on the next clock.
- R6: Writing 1 to bit x at address 1 clears done flag x. Bits written as 0 leave their flags unchanged.
- R7: Writing 1 to bit x at address 4 clears status bit x. `irq` drops in that cycle only when no other status bit remains set.
- R8: A cleared status bit stays 0 while its done flag remains 1 and its mask stays 0.
- R9: If a detected rising edge and a done-clear write to the same bit take effect on the same clock, the done flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dev_int | input | N_DEV | Device completion interrupt inputs, asynchronous, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | N_DEV | Register write data |
| rdata | output | N_DEV | Register read data for `addr` |
| irq | output | 1 | Processor interrupt, high while any status bit is set |

## Verification
The bench builds the block with its defaults: two devices and a two-flop synchroniser. With this setting the bench can fix the exact clock on which a flag appears and time a clear write to land on the same edge as a detected input edge. Two devices make it possible to hold two status bits at once. The bench can then show that clearing one status bit keeps `irq` high, and that a masked device does not disturb the unmasked one.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DONE     = 3'd0,
    REG_DONE_CLR = 3'd1,
    REG_MASK     = 3'd2,
    REG_STAT     = 3'd3,
    REG_STAT_CLR = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/fic_rst_sync.sv
module fic_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign rst_n_o = shift_q[STAGES-1];
endmodule

// File: rtl/fic_edge_detect.sv
module fic_edge_detect #(
  parameter int N_DEV       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] pin_i,
  output logic [N_DEV-1:0] rise_o
);
  localparam int LAST = SYNC_STAGES - 1;

  for (genvar g = 0; g < N_DEV; g++) begin : g_dev
    logic [SYNC_STAGES-1:0] sync_q, sync_d;
    logic                   prev_q, prev_d;

    always_comb begin
      sync_d = {sync_q[LAST-1:0], pin_i[g]};
      prev_d = sync_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= sync_d;
        prev_q <= prev_d;
      end
    end

    assign rise_o[g] = sync_q[LAST] & ~prev_q;
  end
endmodule

// File: rtl/fic_flag_bank.sv
module fic_flag_bank #(
  parameter int N_DEV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] set_i,
  input  logic             clr_en_i,
  input  logic [N_DEV-1:0] clr_bits_i,
  output logic [N_DEV-1:0] flags_o
);
  logic [N_DEV-1:0] flags_q, flags_d, clr_eff;
  logic             upd_en;

  always_comb begin
    clr_eff = clr_en_i ? clr_bits_i : '0;
    // a set on the same edge as a clear wins
    flags_d = (flags_q & ~clr_eff) | set_i;
    upd_en  = clr_en_i | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/fic_reg_port.sv
module fic_reg_port
  import fic_pkg::*;
#(
  parameter int               N_DEV      = 2,
  parameter logic [N_DEV-1:0] MASK_RESET = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_DEV-1:0]  wdata_i,
  input  logic [N_DEV-1:0]  done_i,
  input  logic [N_DEV-1:0]  stat_i,
  output logic [N_DEV-1:0]  mask_o,
  output logic              done_clr_o,
  output logic              stat_clr_o,
  output logic [N_DEV-1:0]  rdata_o
);
  logic [N_DEV-1:0] mask_q;
  logic             mask_we;
  reg_sel_e         sel;

  always_comb begin
    sel        = reg_sel_e'(addr_i);
    mask_we    = wr_en_i && (sel == REG_MASK);
    done_clr_o = wr_en_i && (sel == REG_DONE_CLR);
    stat_clr_o = wr_en_i && (sel == REG_STAT_CLR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_RESET;
    else if (mask_we) mask_q <= wdata_i;
  end

  always_comb begin
    case (sel)
      REG_DONE: rdata_o = done_i;
      REG_MASK: rdata_o = mask_q;
      REG_STAT: rdata_o = stat_i;
      default:  rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/flash_irq_capture.sv
module flash_irq_capture
  import fic_pkg::*;
#(
  parameter int N_DEV       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [N_DEV-1:0]  dev_int,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_DEV-1:0]  wdata,
  output logic [N_DEV-1:0]  rdata,
  output logic              irq
);
  logic             rst_n_sync;
  logic [N_DEV-1:0] edge_hit, done_q, stat_q, mask_q;
  logic [N_DEV-1:0] unmasked, unmasked_prev_q, stat_set;
  logic             done_clr, stat_clr;

  fic_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n_sync)
  );

  fic_edge_detect #(.N_DEV(N_DEV), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n_sync), .pin_i(dev_int), .rise_o(edge_hit)
  );

  fic_flag_bank #(.N_DEV(N_DEV)) u_done (
    .clk(clk), .rst_n(rst_n_sync), .set_i(edge_hit),
    .clr_en_i(done_clr), .clr_bits_i(wdata), .flags_o(done_q)
  );

  // second level fires once per rising of the unmasked done flag
  always_comb begin
    unmasked = done_q & ~mask_q;
    stat_set = unmasked & ~unmasked_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) unmasked_prev_q <= '0;
    else             unmasked_prev_q <= unmasked;
  end

  fic_flag_bank #(.N_DEV(N_DEV)) u_stat (
    .clk(clk), .rst_n(rst_n_sync), .set_i(stat_set),
    .clr_en_i(stat_clr), .clr_bits_i(wdata), .flags_o(stat_q)
  );

  fic_reg_port #(.N_DEV(N_DEV), .MASK_RESET('1)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .done_i(done_q), .stat_i(stat_q), .mask_o(mask_q),
    .done_clr_o(done_clr), .stat_clr_o(stat_clr), .rdata_o(rdata)
  );

  assign irq = |stat_q;
endmodule

// File: rtl/fic_checker.sv
module fic_checker
  import fic_pkg::*;
#(
  parameter int N_DEV = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic [N_DEV-1:0]  done,
  input logic [N_DEV-1:0]  stat,
  input logic [N_DEV-1:0]  mask,
  input logic [N_DEV-1:0]  edge_hit,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N_DEV-1:0]  wdata
);
  AST_IRQ_ON_NEW_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & ~$past(stat))) |-> irq);  // R4

  for (genvar g = 0; g < N_DEV; g++) begin : g_bit
    AST_DONE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done[g]) |-> $past(edge_hit[g]));  // R3

    AST_EDGE_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit[g] |=> done[g]);  // R9

    AST_STATUS_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[g]) |-> $past(done[g] && !mask[g]));  // R4

    AST_MASK_HOLDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (mask[g] && !stat[g]) |=> !stat[g]);  // R5

    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_DONE_CLR && wdata[g] && !edge_hit[g]) |=> !done[g]);  // R6

    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_STAT_CLR && wdata[g] && !done[g]) |=> !stat[g]);  // R7
  end
endmodule

bind flash_irq_capture fic_checker #(.N_DEV(N_DEV)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .irq(irq), .done(done_q), .stat(stat_q),
  .mask(mask_q), .edge_hit(edge_hit), .wr_en(wr_en), .addr(addr), .wdata(wdata)
);

// File: tb/flash_irq_capture_tb_top.sv
module flash_irq_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 2;
  localparam logic [2:0] A_DONE = 3'd0, A_DCLR = 3'd1, A_MASK = 3'd2,
                         A_STAT = 3'd3, A_SCLR = 3'd4;

  logic         clk = 1'b0;
  logic         arst_n;
  logic [N-1:0] dev_int;
  logic         wr_en;
  logic [2:0]   addr;
  logic [N-1:0] wdata;
  logic [N-1:0] rdata;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_irq_capture #(.N_DEV(N), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .arst_n(arst_n), .dev_int(dev_int), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [N-1:0] exp);
    logic [N-1:0] v;
    rd(a, v);
    chk(req, 32'(v), 32'(exp));
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic t_reset();
    arst_n = 1'b0; dev_int = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    tick(3);
    chk_reg("R1 done after reset", A_DONE, 2'b00);
    chk_reg("R1 status after reset", A_STAT, 2'b00);
    chk_reg("R1 mask after reset", A_MASK, 2'b11);
    chk("R1 irq after reset", 32'(irq), 0);
    arst_n = 1'b1;
    tick(5);
    chk_reg("R1 clear register reads zero", A_DCLR, 2'b00);
  endtask

  task automatic t_latency();
    wr(A_MASK, 2'b00);
    dev_int[0] = 1'b1;
    tick(2);
    chk_reg("R2 done not before third edge", A_DONE, 2'b00);
    tick(1);
    chk_reg("R2 done after third edge", A_DONE, 2'b01);
    chk_reg("R4 status one clock later", A_STAT, 2'b00);
    tick(1);
    chk_reg("R4 status set", A_STAT, 2'b01);
    chk("R4 irq with status", 32'(irq), 1);
  endtask

  task automatic t_level_and_clear();
    wr(A_DCLR, 2'b10);
    chk_reg("R6 zero bit leaves flag", A_DONE, 2'b01);
    wr(A_DCLR, 2'b01);
    chk_reg("R6 one bit clears flag", A_DONE, 2'b00);
    tick(5);
    chk_reg("R3 held level does not reset flag", A_DONE, 2'b00);
    chk_reg("R6 done clear keeps status", A_STAT, 2'b01);
    dev_int[0] = 1'b0;
    tick(6);
    chk_reg("R3 falling edge ignored", A_DONE, 2'b00);
    wr(A_SCLR, 2'b01);
    chk_reg("R7 status cleared", A_STAT, 2'b00);
    chk("R7 irq low when none left", 32'(irq), 0);
  endtask

  task automatic t_no_refire();
    dev_int[0] = 1'b1;
    tick(6);
    chk_reg("R4 second event status", A_STAT, 2'b01);
    wr(A_SCLR, 2'b01);
    tick(4);
    chk_reg("R8 status stays clear", A_STAT, 2'b00);
    chk("R8 irq stays low", 32'(irq), 0);
    wr(A_DCLR, 2'b01);
    dev_int[0] = 1'b0;
    tick(4);
  endtask

  task automatic t_mask();
    wr(A_MASK, 2'b10);
    dev_int[1] = 1'b1;
    tick(6);
    chk_reg("R5 masked done still latched", A_DONE, 2'b10);
    chk_reg("R5 masked status stays clear", A_STAT, 2'b00);
    chk("R5 masked irq low", 32'(irq), 0);
    wr(A_MASK, 2'b00);
    tick(1);
    chk_reg("R5 unmask with pending done", A_STAT, 2'b10);
    chk("R5 irq after unmask", 32'(irq), 1);
  endtask

  task automatic t_two_sources();
    dev_int[0] = 1'b1;
    tick(6);
    chk_reg("R4 both status bits", A_STAT, 2'b11);
    wr(A_SCLR, 2'b10);
    chk_reg("R7 one status cleared", A_STAT, 2'b01);
    chk("R7 irq stays with other bit", 32'(irq), 1);
    wr(A_SCLR, 2'b01);
    chk("R7 irq drops with last bit", 32'(irq), 0);
    wr(A_DCLR, 2'b11);
    chk_reg("R6 both done cleared", A_DONE, 2'b00);
    dev_int = '0;
    tick(4);
  endtask

  task automatic t_set_wins();
    dev_int[0] = 1'b1;
    tick(6);
    dev_int[0] = 1'b0;
    tick(6);
    wr(A_SCLR, 2'b01);
    chk_reg("R9 done primed", A_DONE, 2'b01);
    dev_int[0] = 1'b1;
    tick(1);
    wr(A_DCLR, 2'b01);
    chk_reg("R9 set beats clear", A_DONE, 2'b01);
    wr(A_DCLR, 2'b01);
    chk_reg("R6 later clear works", A_DONE, 2'b00);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_level_and_clear();
    t_no_refire();
    t_mask();
    t_two_sources();
    t_set_wins();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule